// File: doc/BRIEF.md
# Simplified UART Register Front End

This block is the host-facing register file of a small serial port. A 32-bit word-access register bus reads and writes a set of registers laid out like a reduced 16550; the line side exchanges bytes over two valid/ready streams. Received bytes enter an eight-entry circular buffer. The host reads them out through the data register. Bytes written to the data register leave on the transmit stream through a one-entry holding slot.

Status registers return fixed synthetic patterns that always report an empty, idle transmitter, with live bits for received data and the buffer fill level. A single interrupt line combines a receive-data source and an always-ready transmit source. The interrupt-identify register reports the receive source ahead of the transmit source. Framing, baud generation, line and modem control and the scratch register are not built: their addresses read zero and ignore writes.

Top module: `muart_top`

## Requirements
- R1: After reset the interrupt line is low, rx_ready_o is high, tx_valid_o is low, the enables are zero and the buffer is empty, so a read of offset 0x24 returns 0x0000030E.
- R2: The receive buffer holds 8 bytes in arrival order. A byte is taken only in a cycle with rx_valid_i and rx_ready_o both high. rx_ready_o is low exactly while 8 bytes are held, and a byte offered then is not stored.
- R3: A read of offset 0x00 returns the oldest byte in bits 7:0 and removes it. A read while the buffer is empty returns the entry at the current read position and changes no state.
- R4: Offset 0x04 keeps only write-data bits 1 (transmit enable) and 0 (receive enable). A read returns 0xC0 ORed with those two bits.
- R5: irq_o is high when the transmit enable is set, or when the receive enable is set and the buffer holds data; otherwise it is low.
- R6: A read of offset 0x08 returns 0xC0, ORed with 0x04 when the buffer holds data or 0x02 when it is empty, and ORed with 0x01 when irq_o is low.
- R7: A write to offset 0x08 with write-data bit 1 set empties the buffer, and it wins over a byte taken in the same cycle. The read position is kept. A write with bit 1 clear changes nothing.
- R8: A read of offset 0x14 returns 0x60, ORed with 0x01 when the buffer holds data.
- R9: Offset 0x20 reads 0x3 and ignores writes. Offset 0x24 reads 0x30E, ORed with 0x01 when data is held, with the fill count (0 to 8) in bits 19:16.
- R10: Offsets 0x0C, 0x10, 0x18, 0x1C, 0x28 and 0x2C to 0x3C read zero, and writes to them change no state. bus_rdata_o is zero when bus_re_i is low. Address bits 1:0 are ignored.
- R11: A write to offset 0x00 places write-data bits 7:0 on tx_data_o with tx_valid_o high. The byte is held stable until a cycle with tx_ready_i high. A write is accepted when the slot is empty or is being drained in that cycle. Otherwise bus_wait_o is high and the write has no effect until it is retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Byte address within the 0x40 window |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read strobe; data-register reads pop at the clock edge |
| bus_rdata_o | output | 32 | Read data, combinational from address and state |
| bus_wait_o | output | 1 | Data write refused because the transmit slot is full |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Buffer has space |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Line side takes the byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong fill count shows in the same cycle in several places: the fill field at 0x24, the data-available bits at 0x14 and 0x08, rx_ready_o and irq_o. A wrong read position shows as a wrong byte on the next data read. A lost or doubled transmit byte shows as a tx_data_o value that differs from the bench's holding model in the cycle after the write. The bench checks every output in every cycle against its own model, so any divergence is reported in the cycle it first appears.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // word index = byte offset >> 2
  localparam int unsigned IDX_DATA  = 0;
  localparam int unsigned IDX_IEN   = 1;
  localparam int unsigned IDX_IID   = 2;
  localparam int unsigned IDX_LSTAT = 5;
  localparam int unsigned IDX_XCTL  = 8;
  localparam int unsigned IDX_XSTAT = 9;

  localparam logic [BUS_W-1:0] IEN_BASE   = 32'h0000_00C0;
  localparam logic [BUS_W-1:0] IID_BASE   = 32'h0000_00C0;
  localparam logic [BUS_W-1:0] LSTAT_BASE = 32'h0000_0060;
  localparam logic [BUS_W-1:0] XCTL_VAL   = 32'h0000_0003;
  localparam logic [BUS_W-1:0] XSTAT_BASE = 32'h0000_030E;
  localparam int unsigned      XSTAT_FILL_LSB = 16;

  typedef struct packed {
    logic tx;
    logic rx;
  } ien_t;
endpackage

// File: rtl/muart_rx_fifo.sv
module muart_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_valid_i,
  output logic          push_ready_o,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [PW:0]   slot_sum;
  logic [PW-1:0] wr_slot;
  logic          push, pop;

  assign push_ready_o = (count_q < CW'(DEPTH));
  assign push         = push_valid_i && push_ready_o;
  assign pop          = pop_i && (count_q != '0);

  // write slot = read position + count, modulo DEPTH
  assign slot_sum = (PW+1)'(rd_ptr_q) + (PW+1)'(count_q);
  assign wr_slot  = (slot_sum >= (PW+1)'(DEPTH)) ? PW'(slot_sum - (PW+1)'(DEPTH))
                                                 : PW'(slot_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[wr_slot] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (pop) rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (flush_i)          count_q <= '0;
      else if (push && !pop) count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_refuses_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH) && push_valid_i && !pop_i && !flush_i) |=> count_q == CW'(DEPTH));
  assert_empty_pop_still_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_q == '0) |=> $stable(rd_ptr_q));
  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && $stable(rd_ptr_q)));
endmodule

// File: rtl/muart_tx_hold.sv
module muart_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_wait_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          drain, take;

  assign drain     = full_q && tx_ready_i;
  assign take      = wr_i && (!full_q || tx_ready_i);
  assign wr_wait_o = wr_i && full_q && !tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (drain) begin
        full_q <= 1'b0;
      end
    end
  end

  assign tx_valid_o = full_q;
  assign tx_data_o  = data_q;

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_tx_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_wait_o) |=> (tx_valid_o && tx_data_o == $past(wr_data_i)));
endmodule

// File: rtl/muart_irq.sv
module muart_irq
  import muart_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ien_t ien_i,
  input  logic has_data_i,
  output logic rx_pend_o,
  output logic tx_pend_o,
  output logic irq_o
);
  assign rx_pend_o = ien_i.rx && has_data_i;
  assign tx_pend_o = ien_i.tx;  // transmit path is always drained
  assign irq_o     = rx_pend_o || tx_pend_o;

  assert_tx_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_i.tx |-> irq_o);
  assert_quiet_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_i.tx && !has_data_i) |-> !irq_o);
endmodule

// File: rtl/muart_top.sv
module muart_top
  import muart_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned WW   = AW - 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic              bus_re_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_wait_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic [WW-1:0]     word;
  logic              sel_data, sel_ien, sel_iid;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     count;
  logic              has_data, flush, pop, tx_wr;
  logic              rx_pend, tx_pend;
  ien_t              ien_q;
  logic              unused_bits;

  assign word     = bus_addr_i[AW-1:2];
  assign sel_data = (word == WW'(IDX_DATA));
  assign sel_ien  = (word == WW'(IDX_IEN));
  assign sel_iid  = (word == WW'(IDX_IID));
  assign has_data = (count != '0);

  assign pop   = bus_re_i && sel_data;
  assign flush = bus_we_i && sel_iid && bus_wdata_i[1];
  assign tx_wr = bus_we_i && sel_data;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[BUS_W-1:BYTE_W]};

  muart_rx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rx (
    .clk_i, .rst_ni,
    .push_data_i (rx_data_i),
    .push_valid_i(rx_valid_i),
    .push_ready_o(rx_ready_o),
    .pop_i       (pop),
    .flush_i     (flush),
    .head_o      (head),
    .count_o     (count)
  );

  muart_tx_hold #(.DW(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i      (tx_wr),
    .wr_data_i (bus_wdata_i[BYTE_W-1:0]),
    .wr_wait_o (bus_wait_o),
    .tx_data_o,
    .tx_valid_o,
    .tx_ready_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ien_q <= '0;
    else if (bus_we_i && sel_ien) ien_q <= ien_t'(bus_wdata_i[1:0]);
  end

  muart_irq u_irq (
    .clk_i, .rst_ni,
    .ien_i     (ien_q),
    .has_data_i(has_data),
    .rx_pend_o (rx_pend),
    .tx_pend_o (tx_pend),
    .irq_o
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      case (word)
        WW'(IDX_DATA):  bus_rdata_o = BUS_W'(head);
        WW'(IDX_IEN):   bus_rdata_o = IEN_BASE | BUS_W'(ien_q);
        WW'(IDX_IID):   bus_rdata_o = IID_BASE
                                    | (has_data ? 32'h4 : 32'h2)
                                    | BUS_W'(!(rx_pend || tx_pend));
        WW'(IDX_LSTAT): bus_rdata_o = LSTAT_BASE | BUS_W'(has_data);
        WW'(IDX_XCTL):  bus_rdata_o = XCTL_VAL;
        WW'(IDX_XSTAT): bus_rdata_o = XSTAT_BASE | BUS_W'(has_data)
                                    | (BUS_W'(count) << XSTAT_FILL_LSB);
        default:        bus_rdata_o = '0;
      endcase
    end
  end

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |-> bus_rdata_o == '0);
  assert_ready_tracks_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o == (bus_re_i && word == WW'(IDX_XSTAT)
                   ? bus_rdata_o[XSTAT_FILL_LSB +: CW] != CW'(DEPTH) : rx_ready_o));
endmodule

// File: tb/sim_muart_top.sv
module sim_muart_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bwait;
  logic [7:0]  rxd = '0;
  logic        rxv = 1'b0;
  logic        rxr;
  logic [7:0]  txd;
  logic        txv;
  logic        txr = 1'b0;
  logic        irq;

  always #5 clk = ~clk;

  muart_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_re_i(re),
    .bus_rdata_o(rdata), .bus_wait_o(bwait),
    .rx_data_i(rxd), .rx_valid_i(rxv), .rx_ready_o(rxr),
    .tx_data_o(txd), .tx_valid_o(txv), .tx_ready_i(txr),
    .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_mem [8];
  int         m_rp = 0, m_cnt = 0;
  logic [1:0] m_ien = '0;
  bit         m_hf = 0;
  logic [7:0] m_hd = '0;

  function automatic logic m_irq();
    return m_ien[1] || (m_ien[0] && m_cnt != 0);
  endfunction

  function automatic logic [31:0] exp_rd(input int w);
    logic [31:0] v;
    case (w)
      0: v = {24'h0, m_mem[m_rp]};
      1: v = 32'hC0 | {30'h0, m_ien};
      2: v = 32'hC0 | (m_cnt != 0 ? 32'h4 : 32'h2) | (m_irq() ? 32'h0 : 32'h1);
      5: v = 32'h60 | (m_cnt != 0 ? 32'h1 : 32'h0);
      8: v = 32'h3;
      9: v = 32'h30E | (m_cnt != 0 ? 32'h1 : 32'h0) | (32'(m_cnt) << 16);
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic string req_of(input int w);
    case (w)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      5: return "R8";
      8, 9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit w_en, input bit r_en, input int word, input logic [31:0] wd,
                      input bit rv, input logic [7:0] rd, input bit tr);
    bit push, pop, flush, take;
    @(negedge clk);
    we = w_en; re = r_en; addr = 6'(word * 4) | 6'($urandom % 4);
    wdata = wd; rxv = rv; rxd = rd; txr = tr;
    #2;
    chk(r_en ? req_of(word) : "R10", "rdata", rdata, r_en ? exp_rd(word) : 32'h0);
    chk("R2", "rx_ready", {31'h0, rxr}, {31'h0, m_cnt < 8});
    chk("R5", "irq", {31'h0, irq}, {31'h0, m_irq()});
    chk("R11", "tx_valid", {31'h0, txv}, {31'h0, m_hf});
    if (m_hf) chk("R11", "tx_data", {24'h0, txd}, {24'h0, m_hd});
    chk("R11", "bus_wait", {31'h0, bwait}, {31'h0, w_en && word == 0 && m_hf && !tr});
    @(posedge clk);
    push  = rv && m_cnt < 8;
    pop   = r_en && word == 0 && m_cnt > 0;
    flush = w_en && word == 2 && wd[1];
    take  = w_en && word == 0 && (!m_hf || tr);
    if (push) m_mem[(m_rp + m_cnt) % 8] = rd;
    if (flush) m_cnt = 0;
    else m_cnt = m_cnt + int'(push) - int'(pop);
    if (pop) m_rp = (m_rp + 1) % 8;
    if (w_en && word == 1) m_ien = wd[1:0];
    if (m_hf && tr) m_hf = 0;
    if (take) begin m_hf = 1; m_hd = wd[7:0]; end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd_reg(input int w); step(0, 1, w, 0, 0, 0, 0); endtask
  task automatic wr_reg(input int w, input logic [31:0] d); step(1, 0, w, d, 0, 0, 0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1 chk("R1", "reset irq", {31'h0, irq}, 32'h0);
    chk("R1", "reset rx_ready", {31'h0, rxr}, 32'h1);
    chk("R1", "reset tx_valid", {31'h0, txv}, 32'h0);
    rst_n = 1'b1;
    rd_reg(9);                                    // R1: 0x30E
    // R2: fill, ninth byte refused
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, 8'(8'hA0 + i), 0);
    rd_reg(9); rd_reg(2); rd_reg(5);              // R9 R6 R8 full
    wr_reg(1, 32'hFFFF_FFF3); rd_reg(1);          // R4
    wr_reg(1, 32'h1); rd_reg(2);                  // R5 rx only
    for (int i = 0; i < 8; i++) rd_reg(0);        // R3 in order
    rd_reg(0); rd_reg(0); rd_reg(9);              // R3 empty read stale
    rd_reg(2);                                    // R6 empty, none pending
    step(0, 0, 0, 0, 1, 8'h5A, 0); step(0, 0, 0, 0, 1, 8'h5B, 0);
    wr_reg(2, 32'h1); rd_reg(9);                  // R7 bit1 clear: no flush
    step(1, 0, 2, 32'h2, 1, 8'h77, 0);            // R7 flush beats push
    rd_reg(9); rd_reg(0);
    wr_reg(8, 32'h0); rd_reg(8);                  // R9 writes ignored
    for (int w = 3; w < 16; w++) if (w != 5 && w != 8 && w != 9) begin
      wr_reg(w, 32'hFFFF_FFFF); rd_reg(w);        // R10
    end
    rd_reg(1); rd_reg(9);
    wr_reg(0, 32'h1234_56C3); wr_reg(0, 32'h99); // R11 second write waits
    idle(); step(1, 0, 0, 32'h99, 0, 0, 1); idle();
    step(0, 0, 0, 0, 0, 0, 1); idle();
    // random mix
    for (int k = 0; k < 6000; k++) begin
      int op, w;
      op = int'($urandom % 8);
      w  = int'($urandom % 16);
      if ($urandom % 3 == 0) w = int'($urandom % 3);
      step(op == 0 || op == 1, op >= 2 && op <= 4, w,
           (w == 2 && $urandom % 8 != 0) ? ($urandom & 32'hFFFF_FFFD) : $urandom,
           $urandom % 2 == 0, 8'($urandom), $urandom % 2 == 0);
    end
    finish_run();
  end
endmodule